// File: doc/BRIEF.md
# Data-Strobe Link Transmitter with Rate Control

This block turns a stream of link tokens into the two-wire data/strobe line signalling used on point-to-point serial links. A token source offers either a data byte or an end-of-packet marker through a valid/ready handshake. The block adds the per-token parity bit and shifts the bits out at a programmable bit rate. When nothing is offered at a token boundary, the line carries Null (an escape followed by a flow-control token). This keeps the far end in step.

The bit rate is held as a divisor code in a small register inside the block. The register is written through `rateLoad`/`rateCode`, and reset loads the 10 Mbit/s code. `SLOW_DIV` is the number of system clocks per bit at 10 Mbit/s. Codes below `SLOW_DIV` give faster rates, one clock per bit at the fastest. Three more codes give the half, quarter and eighth rates, and the eighth rate is the floor. With power-save enabled, Null units go out at the 10 Mbit/s period. Real traffic goes out at the programmed period again as soon as it is taken. Any change of period starts only at a unit boundary.

Top module: `ds_link_tx`

## Requirements
- R1: While and after reset, `dsData` and `dsStrobe` are low and `txReady` is low during reset. The rate register resets to the 10 Mbit/s code, so the first units go out at `SLOW_DIV` clocks per bit.
- R2: A data token is sent as a parity bit, then a flag bit of 0, then the 8 data bits least significant first.
- R3: A control token is sent as a parity bit, then a flag bit of 1, then 2 type bits, low bit first: 00 flow-control, 01 end-of-packet one, 10 end-of-packet two, 11 escape. When `txEop` is high, the token is end-of-packet one if `eopSel`=0 and end-of-packet two if `eopSel`=1.
- R4: A token is taken on a clock edge where `txValid` and `txReady` are both high, and its first bit appears on the line at that edge. At a unit boundary with no token offered, a Null (escape, then flow-control) is sent as one unit.
- R5: Each parity bit makes the XOR of the previous token's data or type bits, this parity bit and this flag bit equal to 1. The token before the first one counts as all zero.
- R6: Exactly one of `dsData` and `dsStrobe` changes per bit. The strobe toggles whenever the data line keeps its value.
- R7: A rate code c below `SLOW_DIV` gives a bit period of c+1 clocks.
- R8: Code `SLOW_DIV` gives 2·`SLOW_DIV` clocks per bit and code `SLOW_DIV`+1 gives 4·`SLOW_DIV`. Every higher code gives 8·`SLOW_DIV`, and no bit is ever longer than that.
- R9: With `psEnable` high, Null units use `SLOW_DIV` clocks per bit, while data and end-of-packet tokens use the programmed period.
- R10: A new rate code or a power-save change takes effect only at a unit boundary, so every bit of a token has the same period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the divider counts its cycles |
| rst | input | 1 | Synchronous active-high reset |
| rateLoad | input | 1 | Writes `rateCode` into the rate register |
| rateCode | input | RATE_W | Bit-rate divisor code |
| psEnable | input | 1 | Send Null units at the 10 Mbit/s period |
| eopSel | input | 1 | 0 selects end-of-packet one, 1 selects end-of-packet two |
| txValid | input | 1 | A token is offered |
| txEop | input | 1 | The offered token is an end-of-packet marker |
| txData | input | 8 | Data byte of the offered token |
| txReady | output | 1 | The offered token is taken on this edge |
| dsData | output | 1 | Data line |
| dsStrobe | output | 1 | Strobe line |

## Verification
The divider's choice of period and the token encoder's choice of unit are made on the same clock edge. At that boundary a rate write, a power-save change or a newly offered token can all arrive together. The bench causes this by writing a new rate code while a slow token is still on the line, and by offering a token while power-save Nulls are running at the slow period. It recovers every token from the two lines and measures the interval of each bit. It then judges that no token mixes two periods, and that each unit uses the period of the kind of unit it is.

// File: rtl/dstx_pkg.sv
`timescale 1ns/1ps
package dstx_pkg;
  typedef enum logic [1:0] {
    UNIT_DATA = 2'd0,
    UNIT_EOP  = 2'd1,
    UNIT_NULL = 2'd2
  } unitKind_e;

  // Strobes from sequencing control to the bit datapath
  typedef struct packed {
    logic      bitTick;  // one bit period elapsed
    logic      load;     // start of a new unit on this tick
    unitKind_e kind;     // what the new unit is
  } txStrobe_t;
endpackage

// File: rtl/dstx_ctrl.sv
`timescale 1ns/1ps
module dstx_ctrl
  import dstx_pkg::*;
#(
  parameter int SLOW_DIV = 20,
  parameter int RATE_W   = 8,
  localparam int MAX_PER = 8 * SLOW_DIV,
  localparam int PER_W   = $clog2(MAX_PER + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rateLoad,
  input  logic [RATE_W-1:0] rateCode,
  input  logic              psEnable,
  input  logic              txValid,
  input  logic              txEop,
  input  logic              unitDone,
  output txStrobe_t         strobe,
  output logic              txReady
);
  logic [RATE_W-1:0] rateReg;
  logic [PER_W-1:0]  cnt;
  logic [PER_W-1:0]  curPeriod;
  logic [PER_W-1:0]  progPeriod;
  logic [PER_W-1:0]  selPeriod;
  logic [PER_W-1:0]  nextPeriod;
  unitKind_e         nextKind;

  function automatic logic [PER_W-1:0] codeToPeriod(input logic [RATE_W-1:0] c);
    int ci;
    ci = int'(c);
    if (ci < SLOW_DIV)       return PER_W'(ci + 1);
    else if (ci == SLOW_DIV) return PER_W'(2 * SLOW_DIV);
    else if (ci == SLOW_DIV + 1) return PER_W'(4 * SLOW_DIV);
    else                     return PER_W'(MAX_PER);
  endfunction

  always_comb begin
    if (!txValid)   nextKind = UNIT_NULL;
    else if (txEop) nextKind = UNIT_EOP;
    else            nextKind = UNIT_DATA;
    progPeriod = codeToPeriod(rateReg);
    selPeriod  = (psEnable && nextKind == UNIT_NULL) ? PER_W'(SLOW_DIV) : progPeriod;
    strobe.bitTick = (cnt == '0);
    strobe.load    = strobe.bitTick && unitDone;
    strobe.kind    = nextKind;
    nextPeriod     = strobe.load ? selPeriod : curPeriod;
    txReady        = strobe.load && !rst;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rateReg   <= RATE_W'(SLOW_DIV - 1);
      cnt       <= '0;
      curPeriod <= PER_W'(SLOW_DIV);
    end else begin
      if (rateLoad) rateReg <= rateCode;
      if (strobe.bitTick) cnt <= nextPeriod - PER_W'(1);
      else                cnt <= cnt - PER_W'(1);
      if (strobe.load) curPeriod <= selPeriod;
    end
  end
endmodule

// File: rtl/dstx_datapath.sv
`timescale 1ns/1ps
module dstx_datapath
  import dstx_pkg::*;
#(
  localparam int WORD_W = 10,
  localparam int LEN_W  = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  txStrobe_t  strobe,
  input  logic [7:0] txData,
  input  logic       eopSel,
  output logic       unitDone,
  output logic       dsData,
  output logic       dsStrobe
);
  logic [WORD_W-1:0] sr;
  logic [LEN_W-1:0]  bitsLeft;
  logic              prevXor;
  logic [WORD_W-1:0] unitWord;
  logic [LEN_W-1:0]  unitLen;
  logic              unitXor;
  logic              nextBit;
  logic [1:0]        eopType;

  // Unit word is sent from bit 0 upward: parity, flag, payload
  always_comb begin
    eopType = eopSel ? 2'b10 : 2'b01;
    unique case (strobe.kind)
      UNIT_DATA: begin
        unitWord = {txData, 1'b0, ~prevXor};
        unitLen  = LEN_W'(10);
        unitXor  = ^txData;
      end
      UNIT_EOP: begin
        unitWord = {6'b0, eopType, 1'b1, prevXor};
        unitLen  = LEN_W'(4);
        unitXor  = ^eopType;
      end
      default: begin
        // escape then flow-control; its parity covers the escape type bits
        unitWord = {2'b0, 2'b00, 1'b1, 1'b0, 2'b11, 1'b1, prevXor};
        unitLen  = LEN_W'(8);
        unitXor  = 1'b0;
      end
    endcase
    nextBit  = strobe.load ? unitWord[0] : sr[0];
    unitDone = (bitsLeft == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sr       <= '0;
      bitsLeft <= '0;
      prevXor  <= 1'b0;
      dsData   <= 1'b0;
      dsStrobe <= 1'b0;
    end else if (strobe.bitTick) begin
      if (strobe.load) begin
        sr       <= unitWord >> 1;
        bitsLeft <= unitLen - LEN_W'(1);
        prevXor  <= unitXor;
      end else begin
        sr       <= sr >> 1;
        bitsLeft <= bitsLeft - LEN_W'(1);
      end
      if (nextBit == dsData) dsStrobe <= ~dsStrobe;
      else                   dsData   <= nextBit;
    end
  end
endmodule

// File: rtl/ds_link_tx.sv
`timescale 1ns/1ps
module ds_link_tx
  import dstx_pkg::*;
#(
  parameter int SLOW_DIV = 20,
  parameter int RATE_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rateLoad,
  input  logic [RATE_W-1:0] rateCode,
  input  logic              psEnable,
  input  logic              eopSel,
  input  logic              txValid,
  input  logic              txEop,
  input  logic [7:0]        txData,
  output logic              txReady,
  output logic              dsData,
  output logic              dsStrobe
);
  txStrobe_t strobe;
  logic      unitDone;

  dstx_ctrl #(.SLOW_DIV(SLOW_DIV), .RATE_W(RATE_W)) ctrl_i (
    .clk(clk), .rst(rst), .rateLoad(rateLoad), .rateCode(rateCode),
    .psEnable(psEnable), .txValid(txValid), .txEop(txEop),
    .unitDone(unitDone), .strobe(strobe), .txReady(txReady)
  );

  dstx_datapath dp_i (
    .clk(clk), .rst(rst), .strobe(strobe), .txData(txData), .eopSel(eopSel),
    .unitDone(unitDone), .dsData(dsData), .dsStrobe(dsStrobe)
  );
endmodule

// File: rtl/dstx_checks.sv
`timescale 1ns/1ps
module dstx_checks #(
  parameter int SLOW_DIV = 20
) (
  input logic clk,
  input logic rst,
  input logic txValid,
  input logic txReady,
  input logic dsData,
  input logic dsStrobe
);
  logic lineX;
  int   gapCnt;
  assign lineX = dsData ^ dsStrobe;

  always_ff @(posedge clk) begin
    if (rst) gapCnt <= 0;
    else if (lineX != $past(lineX)) gapCnt <= 1;
    else gapCnt <= gapCnt + 1;
  end

  assert_reset_lines_R1: assert property (@(posedge clk)
    rst |=> (!dsData && !dsStrobe));

  assert_one_line_moves_R6: assert property (@(posedge clk) disable iff (rst)
    !((dsData != $past(dsData)) && (dsStrobe != $past(dsStrobe))));

  assert_take_starts_bit_R4: assert property (@(posedge clk) disable iff (rst)
    (txValid && txReady) |=> (lineX != $past(lineX)));

  assert_period_floor_R8: assert property (@(posedge clk) disable iff (rst)
    gapCnt <= 8 * SLOW_DIV);
endmodule

bind ds_link_tx dstx_checks #(.SLOW_DIV(SLOW_DIV)) chk_i (
  .clk(clk), .rst(rst), .txValid(txValid), .txReady(txReady),
  .dsData(dsData), .dsStrobe(dsStrobe)
);

// File: tb/ds_link_tx_tb_top.sv
`timescale 1ns/1ps
module ds_link_tx_tb_top;
  localparam int SD = 20;
  localparam int MAXT = 4096;
  // token kinds as recovered: 0 FCT, 1 EOP1, 2 EOP2, 3 ESC, 4 data
  logic clk = 0, rst = 1;
  logic rateLoad = 0, psEnable = 0, eopSel = 0, txValid = 0, txEop = 0;
  logic [7:0] rateCode = 0, txData = 0;
  logic txReady, dsData, dsStrobe;
  int checks = 0, errors = 0;
  bit done = 0;

  ds_link_tx #(.SLOW_DIV(SD), .RATE_W(8)) dut_i (
    .clk(clk), .rst(rst), .rateLoad(rateLoad), .rateCode(rateCode),
    .psEnable(psEnable), .eopSel(eopSel), .txValid(txValid), .txEop(txEop),
    .txData(txData), .txReady(txReady), .dsData(dsData), .dsStrobe(dsStrobe)
  );

  always #10 clk = ~clk;

  // line monitor: recovers bits, tokens, parity and bit periods
  int tkKind[MAXT]; int tkVal[MAXT]; int tkPer[MAXT]; bit tkPar[MAXT]; bit tkUni[MAXT];
  int ntok = 0, lineBad = 0, cyc = 0, lastEdge = 0, pos = 0, minI = 0, maxI = 0;
  logic pd = 0, ps = 0, tokP = 0, tokF = 0, prevPar = 0;
  logic [7:0] acc = 0;

  always @(negedge clk) begin
    cyc++;
    if (rst) begin
      pd = 0; ps = 0; pos = 0; prevPar = 0; lastEdge = cyc;
    end else begin
      if ((dsData != pd) && (dsStrobe != ps)) lineBad++;
      if ((dsData ^ dsStrobe) != (pd ^ ps)) begin
        int iv;
        iv = cyc - lastEdge;
        lastEdge = cyc;
        if (pos == 0) tokP = dsData;
        else if (pos == 1) begin tokF = dsData; acc = 0; minI = iv; maxI = iv; end
        else begin
          acc[pos-2] = dsData;
          if (iv < minI) minI = iv;
          if (iv > maxI) maxI = iv;
        end
        pos++;
        if (pos >= 4 && (tokF ? pos == 4 : pos == 10)) begin
          if (ntok < MAXT) begin
            tkKind[ntok] = tokF ? int'(acc[1:0]) : 4;
            tkVal[ntok]  = int'(acc);
            tkPar[ntok]  = ((prevPar ^ tokP ^ tokF) == 1'b1);
            tkPer[ntok]  = maxI;
            tkUni[ntok]  = (minI == maxI);
            ntok++;
          end
          prevPar = tokF ? ^acc[1:0] : ^acc;
          pos = 0;
        end
      end
      pd = dsData; ps = dsStrobe;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic setRate(input int code);
    @(negedge clk); rateLoad = 1; rateCode = 8'(code);
    @(negedge clk); rateLoad = 0;
  endtask

  task automatic offer(input logic [7:0] d, input bit eop);
    @(negedge clk); txValid = 1; txData = d; txEop = eop;
    forever begin
      if (txReady) break;
      @(negedge clk);
    end
    @(posedge clk); #2;
    txValid = 0; txEop = 0;
  endtask

  // index of first data/EOP token recorded at or after start, -1 on timeout
  task automatic findReal(input int start, output int idx);
    idx = -1;
    for (int w = 0; w < 6000 && idx < 0; w++) begin
      @(negedge clk);
      for (int i = start; i < ntok; i++)
        if (idx < 0 && (tkKind[i] == 4 || tkKind[i] == 1 || tkKind[i] == 2)) idx = i;
    end
  endtask

  task automatic waitTok(input int target);
    for (int w = 0; w < 20000 && ntok < target; w++) @(negedge clk);
  endtask

  task automatic testReset();
    @(negedge clk);
    chk(dsData == 0 && dsStrobe == 0, "R1 lines low in reset", {dsData, dsStrobe}, 0);
    chk(txReady == 0, "R1 ready low in reset", txReady, 0);
  endtask

  task automatic testIdle();
    waitTok(6);
    for (int i = 0; i < 6; i++) begin
      chk(tkKind[i] == ((i % 2 == 0) ? 3 : 0), "R4 null is escape then flow-control",
          tkKind[i], (i % 2 == 0) ? 3 : 0);
      chk(tkPar[i], "R5 idle parity", tkPar[i], 1);
    end
    chk(tkPer[1] == SD, "R1 reset rate period", tkPer[1], SD);
    chk(tkPer[4] == SD, "R1 reset rate later unit", tkPer[4], SD);
  endtask

  task automatic testData();
    int s, k;
    setRate(3);
    s = ntok; offer(8'hA5, 0); findReal(s, k);
    chk(k >= 0 && tkKind[k] == 4 && tkVal[k] == 8'hA5, "R2 data byte A5", k >= 0 ? tkVal[k] : -1, 8'hA5);
    chk(k >= 0 && tkPer[k] == 4, "R7 code 3 gives 4 clocks", k >= 0 ? tkPer[k] : -1, 4);
    s = ntok; offer(8'h3C, 0); findReal(s, k);
    chk(k >= 0 && tkVal[k] == 8'h3C && tkPar[k], "R2 data byte 3C with parity", k >= 0 ? tkVal[k] : -1, 8'h3C);
  endtask

  task automatic testEop();
    int s, k;
    eopSel = 0; s = ntok; offer(8'h00, 1); findReal(s, k);
    chk(k >= 0 && tkKind[k] == 1, "R3 end-of-packet one", k >= 0 ? tkKind[k] : -1, 1);
    eopSel = 1; s = ntok; offer(8'hFF, 1); findReal(s, k);
    chk(k >= 0 && tkKind[k] == 2, "R3 end-of-packet two", k >= 0 ? tkKind[k] : -1, 2);
    eopSel = 0;
  endtask

  task automatic testSlow();
    int s, k;
    int codes[3] = '{SD, SD + 1, 255};
    int pers[3]  = '{2 * SD, 4 * SD, 8 * SD};
    for (int j = 0; j < 3; j++) begin
      setRate(codes[j]);
      s = ntok; offer(8'h5A, 0); findReal(s, k);
      chk(k >= 0 && tkPer[k] == pers[j], "R8 slow code period", k >= 0 ? tkPer[k] : -1, pers[j]);
    end
  endtask

  task automatic testMidChange();
    int s, k;
    setRate(SD + 1);
    s = ntok; offer(8'h0F, 0);
    repeat (300) @(negedge clk);
    rateLoad = 1; rateCode = 8'd3;
    @(negedge clk); rateLoad = 0;
    findReal(s, k);
    chk(k >= 0 && tkPer[k] == 4 * SD && tkUni[k], "R10 token keeps its period", k >= 0 ? tkPer[k] : -1, 4 * SD);
    s = ntok; offer(8'hF0, 0); findReal(s, k);
    chk(k >= 0 && tkPer[k] == 4 && tkUni[k], "R10 next token new period", k >= 0 ? tkPer[k] : -1, 4);
  endtask

  task automatic testPowerSave();
    int s, k;
    setRate(0);
    psEnable = 1;
    s = ntok; waitTok(s + 4);
    chk(tkKind[s + 3] == 0 || tkKind[s + 3] == 3, "R9 idle units are null", tkKind[s + 3], 0);
    chk(tkPer[s + 3] == SD, "R9 null at slow period", tkPer[s + 3], SD);
    s = ntok; offer(8'h81, 0); findReal(s, k);
    chk(k >= 0 && tkPer[k] == 1 && tkVal[k] == 8'h81, "R9 data at programmed period", k >= 0 ? tkPer[k] : -1, 1);
    waitTok(k + 3);
    chk(tkPer[k + 2] == SD, "R9 nulls slow again after data", tkPer[k + 2], SD);
    psEnable = 0;
    s = ntok; waitTok(s + 6);
    chk(tkPer[s + 5] == 1, "R7 code 0 gives 1 clock, R9 off", tkPer[s + 5], 1);
  endtask

  task automatic testGlobal();
    int pbad = 0, ubad = 0;
    for (int i = 0; i < ntok; i++) begin
      if (!tkPar[i]) pbad++;
      if (i > 0 && !tkUni[i]) ubad++;
    end
    chk(pbad == 0, "R5 parity of all tokens", pbad, 0);
    chk(ubad == 0, "R10 uniform bits in all tokens", ubad, 0);
    chk(lineBad == 0, "R6 one line moves per bit", lineBad, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rst = 0;
    testIdle();
    testData();
    testEop();
    testSlow();
    testMidChange();
    testPowerSave();
    testGlobal();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule